// File: doc/BRIEF.md
# Master Clock Source Selector

This block drives one master clock pin from one of three sources: a clock recovered by an external PLL, a free-running reference clock, or a serial bit clock divided by 64. A small register port holds an 8-bit control register and a read-only identification register. The control fields pick the source, force the reference clock, enable an automatic fallback to the reference clock when the PLL loses lock, tri-state the pin, and set the polarity of an interrupt pin. A PLL-lock input and a slave-mode input from the serial receiver also enter the decision. Every change of source goes through a glitch-free handover.

A power-down bit, set at reset, holds the clock path and the divider in reset and keeps the clock pin low. The register port keeps working while power-down is set, so software can set up the other fields before clearing the bit to start operation.

Top module: `mcs_clock_select`

## Requirements
- R1: The register at address 0x01 reads as 0x12: identification code 00010 in bits 7:3 and revision 010 in bits 2:0. Writes to it have no effect.
- R2: The control register sits at address 0x02 and resets to 0x80. Its fields are bit 7 power-down, bit 6 force-reference, bit 5 auto-fallback, bits 4:3 output mode and bits 2:1 interrupt polarity. Bit 0 always reads 0. A read returns data one clock after the address is presented, and unused addresses read 0.
- R3: While power-down is 1, the clock pin stays low and the interrupt pin shows its inactive level. The register port still accepts reads and writes.
- R4: When force-reference is 1 and power-down is 0, the pin carries the reference clock whatever the PLL lock state and the auto-fallback bit are.
- R5: When auto-fallback is 1, force-reference is 0 and the PLL-lock input is low, the pin carries the reference clock. When lock returns, the pin goes back to the source that the output mode selects.
- R6: When auto-fallback is 0, loss of PLL lock does not change the source.
- R7: Output mode 00 puts the PLL clock on the pin.
- R8: Output mode 01 with the slave-mode input at 0 puts the serial bit clock divided by 64 on the pin, with a 50% duty cycle.
- R9: Output mode 01 with the slave-mode input at 1, and output mode 11, hold the pin low with its driver enabled.
- R10: Output mode 10 turns off the clock pin driver (high impedance).
- R11: A change of source never produces a high or low pulse shorter than the shorter half-period of the old and new clocks. At most one source is enabled at any time.
- R12: Interrupt polarity 00 gives an active-high pin (pin equals the request), 01 an active-low pin (pin equals the inverted request), and 10 or 11 an open-drain style output that drives low only while the request is pending. The pin is registered, so it lags the request by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register port and control clock |
| rst | input | 1 | Active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| pll_clk | input | 1 | Clock recovered by the PLL |
| ref_clk | input | 1 | Reference (crystal) clock |
| sbclk | input | 1 | Serial bit clock from the audio input |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| sin_slave | input | 1 | Serial input runs in slave mode (1 = divider source not valid) |
| irq_src | input | 1 | Pending interrupt request, synchronous to clk |
| mclk_out | output | 1 | Selected master clock |
| mclk_oe | output | 1 | Driver enable for the master clock pin |
| irq_pin | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin driver enable |

## Verification
The assertions check on every cycle that the identification word reads back fixed, that the reserved control bit reads 0, that power-down keeps the clock low, that the high-impedance mode drops the driver enable, that the active-high interrupt follows its request, that the divider toggles at the end of each half period, and that no two sources are enabled at once. Only the bench scenarios can show which clock actually reaches the pin after a register write or a lock change, the divided clock's period and duty, and the absence of short pulses over a whole handover. These depend on waveforms across several unrelated clock domains, not on a relation between signals at one edge.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_REF  = 2'd2,
    SRC_DIV  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    OM_PLL   = 2'b00,
    OM_SBDIV = 2'b01,
    OM_HIZ   = 2'b10,
    OM_RSVD  = 2'b11
  } omode_e;

  typedef enum logic [1:0] {
    IP_HIGH = 2'b00,
    IP_LOW  = 2'b01,
    IP_OD0  = 2'b10,
    IP_OD1  = 2'b11
  } ipol_e;

  // control fields, MSB first (reserved bit 0 is not carried)
  typedef struct packed {
    logic       pdn;
    logic       force_ref;
    logic       auto_sw;
    logic [1:0] omode;
    logic [1:0] ipol;
  } ctrl_t;

  localparam int NSRC = 3;  // index 0 PLL, 1 reference, 2 divided bit clock

endpackage

// File: rtl/mcs_regs.sv
module mcs_regs
  import mcs_pkg::*;
#(
  parameter int              AW        = 8,
  parameter logic [AW-1:0]   ID_ADDR   = 'h01,
  parameter logic [AW-1:0]   CTRL_ADDR = 'h02,
  parameter logic [4:0]      ID_CODE   = 5'b00010,
  parameter logic [2:0]      REV_CODE  = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output ctrl_t         ctrl
);

  localparam logic [7:0] ID_WORD   = {ID_CODE, REV_CODE};
  localparam logic [7:0] CTRL_RST  = 8'h80;
  localparam logic [7:0] RSVD_MASK = 8'hFE;

  logic [7:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      rdata  <= '0;
    end else begin
      if (we && addr == CTRL_ADDR) ctrl_q <= wdata & RSVD_MASK;
      case (addr)
        ID_ADDR:   rdata <= ID_WORD;
        CTRL_ADDR: rdata <= ctrl_q;
        default:   rdata <= '0;
      endcase
    end
  end

  assign ctrl = ctrl_t'(ctrl_q[7:1]);

  // R1: identification word is fixed whatever was written
  assert_id_fixed_R1: assert property (@(posedge clk) disable iff (rst)
    (addr == ID_ADDR) |=> (rdata == ID_WORD));

  // R2: reserved control bit reads back as zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == CTRL_ADDR) |=> (rdata[0] == 1'b0));

endmodule

// File: rtl/mcs_sync2.sv
module mcs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/mcs_div.sv
module mcs_div #(
  parameter int DIV = 64
) (
  input  logic sbclk,
  input  logic arst,
  output logic clk_div
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge sbclk or posedge arst) begin
    if (arst) begin
      cnt     <= '0;
      clk_div <= 1'b0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      clk_div <= ~clk_div;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  // R8: output flips once per half period of the divided clock
  assert_div_toggle_R8: assert property (@(posedge sbclk) disable iff (arst)
    (cnt == LAST) |=> (clk_div != $past(clk_div)));

endmodule

// File: rtl/mcs_gfswitch.sv
module mcs_gfswitch #(
  parameter int N = 3
) (
  input  logic [N-1:0] src_clk,
  input  logic [N-1:0] req,
  input  logic         arst,
  output logic         clk_out
);

  logic [N-1:0] busy;
  logic [N-1:0] en;
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [1:0] st;
    logic       others;

    always_comb others = |(busy & ~(N'(1) << i));

    always_ff @(negedge src_clk[i] or posedge arst) begin
      if (arst) st <= '0;
      else      st <= {st[0], req[i] & ~others};
    end

    assign busy[i]  = |st;
    assign en[i]    = st[1];
    assign gated[i] = src_clk[i] & st[1];
  end

  assign clk_out = |gated;

  // R11: never two sources on the output at once
  always_comb begin
    if (!arst) begin
      assert_one_src_R11: assert ($onehot0(en));
    end
  end

endmodule

// File: rtl/mcs_clock_select.sv
module mcs_clock_select
  import mcs_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         DIV      = 64,
  parameter logic [2:0] REV_CODE = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          pll_clk,
  input  logic          ref_clk,
  input  logic          sbclk,
  input  logic          pll_lock,
  input  logic          sin_slave,
  input  logic          irq_src,
  output logic          mclk_out,
  output logic          mclk_oe,
  output logic          irq_pin,
  output logic          irq_oe
);

  ctrl_t            ctrl;
  logic [1:0]       async_in;
  logic [1:0]       async_s;
  logic             lock_s;
  logic             slave_s;
  src_e             sel_q;
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  src_clk;
  logic             div_clk;
  logic             path_arst;
  logic             irq_act;

  mcs_regs #(
    .AW       (AW),
    .REV_CODE (REV_CODE)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .ctrl  (ctrl)
  );

  assign async_in = {sin_slave, pll_lock};

  mcs_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (async_s)
  );

  assign lock_s  = async_s[0];
  assign slave_s = async_s[1];

  // source decision: power-down, then force, then fallback, then mode
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SRC_NONE;
    end else if (ctrl.pdn) begin
      sel_q <= SRC_NONE;
    end else if (ctrl.force_ref || (ctrl.auto_sw && !lock_s)) begin
      sel_q <= SRC_REF;
    end else begin
      case (omode_e'(ctrl.omode))
        OM_PLL:   sel_q <= SRC_PLL;
        OM_SBDIV: sel_q <= slave_s ? SRC_NONE : SRC_DIV;
        default:  sel_q <= SRC_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_req
    assign req[i] = (sel_q == src_e'(2'(i + 1)));
  end

  assign path_arst = rst | ctrl.pdn;

  mcs_div #(.DIV(DIV)) u_div (
    .sbclk   (sbclk),
    .arst    (path_arst),
    .clk_div (div_clk)
  );

  assign src_clk = {div_clk, ref_clk, pll_clk};

  mcs_gfswitch #(.N(NSRC)) u_switch (
    .src_clk (src_clk),
    .req     (req),
    .arst    (path_arst),
    .clk_out (mclk_out)
  );

  // pin driver and interrupt polarity, registered
  assign irq_act = irq_src & ~ctrl.pdn;

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_oe <= 1'b1;
      irq_pin <= 1'b0;
      irq_oe  <= 1'b1;
    end else begin
      mclk_oe <= (omode_e'(ctrl.omode) != OM_HIZ);
      case (ipol_e'(ctrl.ipol))
        IP_HIGH: begin irq_pin <= irq_act;  irq_oe <= 1'b1;    end
        IP_LOW:  begin irq_pin <= ~irq_act; irq_oe <= 1'b1;    end
        default: begin irq_pin <= 1'b0;     irq_oe <= irq_act; end
      endcase
    end
  end

  // R3: clock pin quiet while powered down
  assert_pdn_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.pdn |=> !mclk_out);

  // R10: high-impedance mode releases the pin
  assert_hiz_release_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl.omode == OM_HIZ) |=> !mclk_oe);

  // R12: active-high interrupt follows its request one clock later
  assert_irq_high_R12: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.pdn && ctrl.ipol == IP_HIGH) |=> (irq_pin == $past(irq_src) && irq_oe));

endmodule

// File: tb/mcs_clock_select_test.sv
`timescale 1ns/1ps
module mcs_clock_select_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       pll_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       sbclk = 1'b0;
  logic       pll_lock = 1'b1;
  logic       sin_slave = 1'b0;
  logic       irq_src = 1'b0;
  logic       mclk_out, mclk_oe, irq_pin, irq_oe;

  int n_chk = 0;
  int n_err = 0;
  int glitches = 0;
  bit mon_on = 1'b0;
  realtime last_edge = 0.0;

  always #4  clk = ~clk;       // 125 MHz
  always #10 pll_clk = ~pll_clk;
  always #15 ref_clk = ~ref_clk;
  always #5  sbclk = ~sbclk;

  mcs_clock_select uut (
    .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .pll_clk (pll_clk),
    .ref_clk (ref_clk), .sbclk (sbclk), .pll_lock (pll_lock),
    .sin_slave (sin_slave), .irq_src (irq_src), .mclk_out (mclk_out),
    .mclk_oe (mclk_oe), .irq_pin (irq_pin), .irq_oe (irq_oe)
  );

  // pulse-width monitor for R11 (shortest legal half period is 10 ns)
  always @(mclk_out) begin
    if (mon_on && ($realtime - last_edge) < 9.0) glitches++;
    last_edge = $realtime;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic follow(input bit use_ref, input string tag);
    int bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (use_ref) @(posedge ref_clk); else @(posedge pll_clk);
      #3;
      if (mclk_out !== 1'b1) bad++;
      if (use_ref) @(negedge ref_clk); else @(negedge pll_clk);
      #3;
      if (mclk_out !== 1'b0) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic held_low(input string tag);
    int bad = 0;
    for (int k = 0; k < 300; k++) begin
      #7;
      if (mclk_out !== 1'b0) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    realtime t0, t1, t2;

    repeat (10) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(8'h02, d); check(d == 8'h80, "R2 control reset value", d, 8'h80);
    rd(8'h01, d); check(d == 8'h12, "R1 identification word", d, 8'h12);
    rd(8'h05, d); check(d == 8'h00, "R2 unused address", d, 0);
    check(mclk_out === 1'b0, "R3 clock low after reset", mclk_out, 0);
    check(irq_pin === 1'b0 && irq_oe === 1'b1, "R3 irq inactive after reset", irq_pin, 0);

    // identification register ignores writes
    wr(8'h01, 8'hFF);
    rd(8'h01, d); check(d == 8'h12, "R1 write to id ignored", d, 8'h12);

    // full sweep of control values
    for (int v = 0; v < 256; v++) begin
      wr(8'h02, 8'(v));
      rd(8'h02, d);
      check(d == (8'(v) & 8'hFE), "R2 control readback", d, v & 8'hFE);
    end

    // power-down with PLL mode, port still usable
    wr(8'h02, 8'h80);
    #2000;
    held_low("R3 power-down keeps clock low");
    rd(8'h02, d); check(d == 8'h80, "R3 port readable in power-down", d, 8'h80);

    // mode 00, PLL clock
    wr(8'h02, 8'h00);
    #2000;
    mon_on = 1'b1;
    follow(1'b0, "R7 PLL clock on pin");
    check(mclk_oe === 1'b1, "R7 driver enabled", mclk_oe, 1);

    // lock lost without fallback
    pll_lock = 1'b0;
    #2000;
    follow(1'b0, "R6 no switch with fallback off");

    // fallback on
    wr(8'h02, 8'h20);
    #2000;
    follow(1'b1, "R5 fallback to reference");
    pll_lock = 1'b1;
    #2000;
    follow(1'b0, "R5 return to PLL on relock");

    // force reference
    wr(8'h02, 8'h60);
    #2000;
    follow(1'b1, "R4 forced reference with lock");
    wr(8'h02, 8'h40);
    pll_lock = 1'b0;
    #2000;
    follow(1'b1, "R4 forced reference without lock");
    pll_lock = 1'b1;

    // divided bit clock
    wr(8'h02, 8'h08);
    #5000;
    @(posedge mclk_out); t0 = $realtime;
    @(negedge mclk_out); t1 = $realtime;
    @(posedge mclk_out); t2 = $realtime;
    check(int'(t1 - t0) == 320, "R8 divided clock high time", int'(t1 - t0), 320);
    check(int'(t2 - t0) == 640, "R8 divided clock period", int'(t2 - t0), 640);

    sin_slave = 1'b1;
    #5000;
    held_low("R9 divider mode while slave");
    check(mclk_oe === 1'b1, "R9 driver stays enabled", mclk_oe, 1);
    sin_slave = 1'b0;

    wr(8'h02, 8'h18);
    #5000;
    held_low("R9 reserved mode holds low");

    wr(8'h02, 8'h10);
    repeat (3) @(negedge clk);
    check(mclk_oe === 1'b0, "R10 high impedance mode", mclk_oe, 0);

    // rapid lock toggling with fallback, PLL mode
    wr(8'h02, 8'h20);
    for (int k = 0; k < 12; k++) begin
      pll_lock = ~pll_lock;
      #(170 + 37 * k);
    end
    pll_lock = 1'b1;
    #2000;
    follow(1'b0, "R11 settles on PLL after toggling");
    mon_on = 1'b0;
    check(glitches == 0, "R11 no short pulses on handover", glitches, 0);

    // interrupt polarity sweep
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        wr(8'h02, 8'(p << 1));
        irq_src = 1'(s);
        repeat (3) @(negedge clk);
        if (p == 0) begin
          check(irq_pin === 1'(s) && irq_oe === 1'b1, "R12 active high", irq_pin, s);
        end else if (p == 1) begin
          check(irq_pin === ~1'(s) && irq_oe === 1'b1, "R12 active low", irq_pin, 1 - s);
        end else begin
          check(irq_pin === 1'b0 && irq_oe === 1'(s), "R12 open drain", irq_oe, s);
        end
      end
    end

    // interrupt inactive in power-down
    wr(8'h02, 8'h82);
    irq_src = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_pin === 1'b1, "R3 active-low irq idle in power-down", irq_pin, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule